// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block fetches per-channel frame descriptors for a display controller. A frame-start pulse begins one pass over the channels in ascending order. For each enabled channel, the fetcher chooses a descriptor address. A pending branch supplies that address. When no branch is pending, the channel's stored next pointer supplies it. The fetcher then reads four 32-bit words through a request/valid memory read port and loads them into the channel's registers.

The fetcher checks every descriptor address against a configured memory window. It also checks each loaded source address against the same window. A problem is reported as a one-cycle per-channel bus-error event. A branch taken with its interrupt flag set produces a one-cycle branch-status event for the interrupt unit. A single-cycle done pulse closes the pass. Software writes the next pointer and the branch register through a small write port. All channel state can be read back through a selector-driven read port.

Top module: `frame_desc_fetcher`

## Requirements
- R1: After reset, every channel register reads zero, no memory request is raised, and no event or done pulse occurs.
- R2: A fetch reads the four words at ptr, ptr+4, ptr+8 and ptr+12. In that order they load the next pointer (rd_sel_i=0), source (1), frame ID (2) and command (3). The next pass on that channel starts from the newly loaded next pointer.
- R3: A software write to the next pointer (wr_branch_i=0) keeps only bits 31:4. A write to the branch register (wr_branch_i=1, read back at rd_sel_i=4) is masked with 0xFFFFFFF3.
- R4: When branch bit 0 (pending) is set on an enabled channel, the fetch uses branch bits 31:4 as the descriptor address instead of the next pointer. Bit 0 is cleared and every other branch bit is kept.
- R5: A branch-status event (bs_evt_o bit of the channel) is raised only when both bit 0 and bit 1 of the branch register are set at the fetch. Neither bit alone raises it.
- R6: A descriptor is read only if ptr >= MEM_BASE and ptr+16 <= MEM_BASE+MEM_SIZE. Otherwise the fetcher issues no reads for that channel, and the channel's next pointer, frame ID and command are kept.
- R7: At every frame start, the source register of every channel, enabled or not, is cleared before any fetch.
- R8: After its fetch step, an enabled channel raises a bus-error event (ber_evt_o bit of the channel) if its source is zero, below MEM_BASE, or above MEM_BASE+MEM_SIZE. The upper bound itself is accepted.
- R9: The enables are:
  - channel 0 by lcd_en_i;
  - channel 1 by ovl1_en_i or dual_scan_i;
  - channels 2 to 4 by ovl2_en_i;
  - channel 5 by cursor_en_i;
  - channel 6 never.

  A disabled channel issues no reads and raises no events.
- R10: Channels are serviced in ascending order with at most one read outstanding. A request holds a stable address until mem_valid_i is seen.
- R11: Exactly one done pulse follows each pass. A frame-start pulse arriving while a pass is running is ignored.
- R12: Read selector 5 returns command bits 20:2 with all other bits zero (the length in bytes). Selector 6 returns command bit 26 (the palette-load flag) in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Pulse starting one fetch pass |
| lcd_en_i | input | 1 | Controller enable (channel 0) |
| dual_scan_i | input | 1 | Dual-scan mode (channel 1) |
| ovl1_en_i | input | 1 | Overlay 1 enable (channel 1) |
| ovl2_en_i | input | 1 | Overlay 2 enable (channels 2-4) |
| cursor_en_i | input | 1 | Cursor enable (channel 5) |
| wr_en_i | input | 1 | Software register write strobe |
| wr_branch_i | input | 1 | 1 writes branch register, 0 writes next pointer |
| wr_ch_i | input | 3 | Channel of the write |
| wr_data_i | input | 32 | Write data |
| rd_ch_i | input | 3 | Channel of the read-back |
| rd_sel_i | input | 3 | Read selector (0 next, 1 source, 2 ID, 3 command, 4 branch, 5 length, 6 palette) |
| rd_data_o | output | 32 | Read-back data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_valid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 32 | Read data |
| bs_evt_o | output | 7 | Per-channel branch-status event pulse |
| ber_evt_o | output | 7 | Per-channel bus-error event pulse |
| done_o | output | 1 | Pass complete pulse |

## Verification
The bench targets the window edges:
- a descriptor ending exactly at the top of the window;
- one starting at the top of the window;
- one below the base;
- a source equal to the upper bound;
- a source just beyond it;
- a zero source.

A design with an off-by-one bound would fetch a descriptor it must skip, or raise a bus error it must not. Branch cases separate pending from interrupt-enable. A design that tested only one of the two bits would fire a spurious branch event or leave the pending bit set, and would then refetch from the branch address on the following frame.

Changing enable sets and a second frame-start pulse in mid-pass show any wrong channel mapping, because an out-of-order channel or a restarted pass breaks the expected address sequence. A stale source on a disabled channel exposes a missing clear.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_READ, ST_CHK} fdf_state_e;

  localparam int BR_PEND_BIT = 0;
  localparam int BR_INT_BIT  = 1;
  localparam int CMD_PAL_BIT = 26;
  localparam int LEN_TOP_BIT = 20;

  localparam logic [2:0] RS_NEXT = 3'd0;
  localparam logic [2:0] RS_SRC  = 3'd1;
  localparam logic [2:0] RS_ID   = 3'd2;
  localparam logic [2:0] RS_CMD  = 3'd3;
  localparam logic [2:0] RS_BR   = 3'd4;
  localparam logic [2:0] RS_LEN  = 3'd5;
  localparam logic [2:0] RS_PAL  = 3'd6;
endpackage

// File: rtl/fdf_chan_regs.sv
module fdf_chan_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_next_we_i,
  input  logic         sw_br_we_i,
  input  logic [W-1:0] sw_data_i,
  input  logic         clr_src_i,
  input  logic         ld_en_i,
  input  logic [1:0]   ld_idx_i,
  input  logic [W-1:0] ld_data_i,
  input  logic         br_take_i,
  output logic [W-1:0] next_o,
  output logic [W-1:0] src_o,
  output logic [W-1:0] id_o,
  output logic [W-1:0] cmd_o,
  output logic [W-1:0] br_o
);
  import fdf_pkg::*;

  localparam logic [W-1:0] NEXT_MASK = ~W'(15);
  localparam logic [W-1:0] BR_MASK   = ~W'(12);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_o <= '0;
      src_o  <= '0;
      id_o   <= '0;
      cmd_o  <= '0;
      br_o   <= '0;
    end else begin
      if (sw_next_we_i) next_o <= sw_data_i & NEXT_MASK;
      if (sw_br_we_i) br_o <= sw_data_i & BR_MASK;
      else if (br_take_i) br_o[BR_PEND_BIT] <= 1'b0;
      if (clr_src_i) src_o <= '0;
      // descriptor load wins over a same-cycle software write
      if (ld_en_i) begin
        case (ld_idx_i)
          2'd0: next_o <= ld_data_i;
          2'd1: src_o  <= ld_data_i;
          2'd2: id_o   <= ld_data_i;
          default: cmd_o <= ld_data_i;
        endcase
      end
    end
  end

  AST_NEXT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_next_we_i && !(ld_en_i && ld_idx_i == 2'd0) |=> next_o[3:0] == 4'd0); // R3
  AST_BRANCH_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_take_i && !sw_br_we_i |=> !br_o[BR_PEND_BIT]); // R4
  AST_SRC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_src_i && !ld_en_i |=> src_o == '0); // R7
endmodule

// File: rtl/fdf_win_chk.sv
module fdf_win_chk #(
  parameter int unsigned  W        = 32,
  parameter logic [W-1:0] MEM_BASE = 32'h0000_1000,
  parameter logic [W-1:0] MEM_SIZE = 32'h0000_1000
) (
  input  logic [W-1:0] desc_ptr_i,
  input  logic [W-1:0] src_i,
  output logic         desc_ok_o,
  output logic         src_ok_o
);
  localparam logic [W:0] LO = {1'b0, MEM_BASE};
  localparam logic [W:0] HI = {1'b0, MEM_BASE} + {1'b0, MEM_SIZE};

  logic [W:0] ptr_x, src_x;
  assign ptr_x = {1'b0, desc_ptr_i};
  assign src_x = {1'b0, src_i};

  // whole 16-byte descriptor must sit inside the window
  assign desc_ok_o = (ptr_x >= LO) && (ptr_x + (W+1)'(16) <= HI);
  // upper bound itself is accepted for the source
  assign src_ok_o  = (src_i != '0) && (src_x >= LO) && (src_x <= HI);
endmodule

// File: rtl/fdf_seq.sv
module fdf_seq #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned W      = 32,
  localparam int unsigned CW    = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [W-1:0]      cur_next_i,
  input  logic [W-1:0]      cur_br_i,
  input  logic              desc_ok_i,
  input  logic              src_ok_i,
  input  logic              mem_valid_i,
  output logic [CW-1:0]     cur_ch_o,
  output logic [W-1:0]      sel_ptr_o,
  output logic              clr_src_o,
  output logic              br_take_o,
  output logic              ld_en_o,
  output logic [1:0]        ld_idx_o,
  output logic              mem_req_o,
  output logic [W-1:0]      mem_addr_o,
  output logic [NUM_CH-1:0] bs_evt_o,
  output logic [NUM_CH-1:0] ber_evt_o,
  output logic              done_o
);
  import fdf_pkg::*;

  localparam logic [CW-1:0] LAST_CH = CW'(NUM_CH - 1);

  fdf_state_e        state_q;
  logic [CW-1:0]     ch_q;
  logic [1:0]        idx_q;
  logic [W-1:0]      ptr_q;
  logic [NUM_CH-1:0] bs_q, ber_q;
  logic              done_q;
  logic              pend, sel_en, last_ch;

  assign pend      = cur_br_i[BR_PEND_BIT];
  assign sel_ptr_o = pend ? (cur_br_i & ~W'(15)) : cur_next_i;
  assign sel_en    = (state_q == ST_SEL) && ch_en_i[ch_q];
  assign br_take_o = sel_en && pend;
  assign clr_src_o = (state_q == ST_IDLE) && frame_start_i;
  assign mem_req_o = (state_q == ST_READ);
  assign mem_addr_o = ptr_q + W'({idx_q, 2'b00});
  assign ld_en_o   = mem_req_o && mem_valid_i;
  assign ld_idx_o  = idx_q;
  assign last_ch   = (ch_q == LAST_CH);
  assign cur_ch_o  = ch_q;
  assign bs_evt_o  = bs_q;
  assign ber_evt_o = ber_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      idx_q   <= '0;
      ptr_q   <= '0;
      bs_q    <= '0;
      ber_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      bs_q   <= '0;
      ber_q  <= '0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (frame_start_i) begin
            ch_q    <= '0;
            state_q <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (!ch_en_i[ch_q]) begin
            if (last_ch) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              ch_q <= ch_q + CW'(1);
            end
          end else begin
            ptr_q <= sel_ptr_o;
            idx_q <= '0;
            if (pend && cur_br_i[BR_INT_BIT]) bs_q[ch_q] <= 1'b1;
            state_q <= desc_ok_i ? ST_READ : ST_CHK;
          end
        end
        ST_READ: begin
          if (mem_valid_i) begin
            if (idx_q == 2'd3) state_q <= ST_CHK;
            else idx_q <= idx_q + 2'd1;
          end
        end
        default: begin
          if (!src_ok_i) ber_q[ch_q] <= 1'b1;
          if (last_ch) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            ch_q    <= ch_q + CW'(1);
            state_q <= ST_SEL;
          end
        end
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R10
  AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bs_evt_o) && $onehot0(ber_evt_o)); // R10
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o && !$past(done_o)); // R11
  AST_BS_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bs_evt_o != '0) |-> $past(br_take_o)); // R5
endmodule

// File: rtl/frame_desc_fetcher.sv
module frame_desc_fetcher #(
  parameter int unsigned  NUM_CH   = 7,
  parameter int unsigned  W        = 32,
  parameter logic [W-1:0] MEM_BASE = 32'h0000_1000,
  parameter logic [W-1:0] MEM_SIZE = 32'h0000_1000,
  localparam int unsigned CW       = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              lcd_en_i,
  input  logic              dual_scan_i,
  input  logic              ovl1_en_i,
  input  logic              ovl2_en_i,
  input  logic              cursor_en_i,
  input  logic              wr_en_i,
  input  logic              wr_branch_i,
  input  logic [CW-1:0]     wr_ch_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [CW-1:0]     rd_ch_i,
  input  logic [2:0]        rd_sel_i,
  output logic [W-1:0]      rd_data_o,
  output logic              mem_req_o,
  output logic [W-1:0]      mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [W-1:0]      mem_rdata_i,
  output logic [NUM_CH-1:0] bs_evt_o,
  output logic [NUM_CH-1:0] ber_evt_o,
  output logic              done_o
);
  import fdf_pkg::*;

  localparam logic [W-1:0] LEN_MASK = (W'(1) << (LEN_TOP_BIT + 1)) - W'(4);

  logic [NUM_CH-1:0] ch_en;
  logic [W-1:0] next_a [NUM_CH];
  logic [W-1:0] src_a  [NUM_CH];
  logic [W-1:0] id_a   [NUM_CH];
  logic [W-1:0] cmd_a  [NUM_CH];
  logic [W-1:0] br_a   [NUM_CH];
  logic [CW-1:0] cur_ch;
  logic [W-1:0]  sel_ptr;
  logic          clr_src, br_take, ld_en, desc_ok, src_ok;
  logic [1:0]    ld_idx;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    if (g == 0) begin : g_en0
      assign ch_en[g] = lcd_en_i;
    end else if (g == 1) begin : g_en1
      assign ch_en[g] = ovl1_en_i | dual_scan_i;
    end else if (g <= 4) begin : g_en_ovl2
      assign ch_en[g] = ovl2_en_i;
    end else if (g == 5) begin : g_en_cur
      assign ch_en[g] = cursor_en_i;
    end else begin : g_en_off
      assign ch_en[g] = 1'b0;
    end

    fdf_chan_regs #(.W(W)) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sw_next_we_i (wr_en_i && !wr_branch_i && (wr_ch_i == CW'(g))),
      .sw_br_we_i   (wr_en_i && wr_branch_i && (wr_ch_i == CW'(g))),
      .sw_data_i    (wr_data_i),
      .clr_src_i    (clr_src),
      .ld_en_i      (ld_en && (cur_ch == CW'(g))),
      .ld_idx_i     (ld_idx),
      .ld_data_i    (mem_rdata_i),
      .br_take_i    (br_take && (cur_ch == CW'(g))),
      .next_o       (next_a[g]),
      .src_o        (src_a[g]),
      .id_o         (id_a[g]),
      .cmd_o        (cmd_a[g]),
      .br_o         (br_a[g])
    );
  end

  fdf_win_chk #(.W(W), .MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE)) u_win (
    .desc_ptr_i (sel_ptr),
    .src_i      (src_a[cur_ch]),
    .desc_ok_o  (desc_ok),
    .src_ok_o   (src_ok)
  );

  fdf_seq #(.NUM_CH(NUM_CH), .W(W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .ch_en_i       (ch_en),
    .cur_next_i    (next_a[cur_ch]),
    .cur_br_i      (br_a[cur_ch]),
    .desc_ok_i     (desc_ok),
    .src_ok_i      (src_ok),
    .mem_valid_i   (mem_valid_i),
    .cur_ch_o      (cur_ch),
    .sel_ptr_o     (sel_ptr),
    .clr_src_o     (clr_src),
    .br_take_o     (br_take),
    .ld_en_o       (ld_en),
    .ld_idx_o      (ld_idx),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .bs_evt_o      (bs_evt_o),
    .ber_evt_o     (ber_evt_o),
    .done_o        (done_o)
  );

  always_comb begin
    case (rd_sel_i)
      RS_NEXT: rd_data_o = next_a[rd_ch_i];
      RS_SRC:  rd_data_o = src_a[rd_ch_i];
      RS_ID:   rd_data_o = id_a[rd_ch_i];
      RS_CMD:  rd_data_o = cmd_a[rd_ch_i];
      RS_BR:   rd_data_o = br_a[rd_ch_i];
      RS_LEN:  rd_data_o = cmd_a[rd_ch_i] & LEN_MASK;
      RS_PAL:  rd_data_o = W'(cmd_a[rd_ch_i][CMD_PAL_BIT]);
      default: rd_data_o = '0;
    endcase
  end

  AST_REQ_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ({1'b0, mem_addr_o} >= {1'b0, MEM_BASE}) &&
                  ({1'b0, mem_addr_o} + (W+1)'(4) <= {1'b0, MEM_BASE} + {1'b0, MEM_SIZE})); // R6
  AST_DISABLED_NO_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bs_evt_o | ber_evt_o) & ~$past(ch_en)) == '0); // R9
endmodule

// File: tb/frame_desc_fetcher_bench.sv
module frame_desc_fetcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 7;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] SIZE = 32'h0000_1000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic frame_start_i = 0, lcd_en_i = 0, dual_scan_i = 0, ovl1_en_i = 0;
  logic ovl2_en_i = 0, cursor_en_i = 0;
  logic wr_en_i = 0, wr_branch_i = 0;
  logic [2:0] wr_ch_i = 0, rd_ch_i = 0, rd_sel_i = 0;
  logic [31:0] wr_data_i = 0, rd_data_o, mem_addr_o, mem_rdata_i = 0;
  logic mem_req_o, mem_valid_i = 0, done_o;
  logic [NCH-1:0] bs_evt_o, ber_evt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_desc_fetcher u_frame_desc_fetcher (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .lcd_en_i(lcd_en_i), .dual_scan_i(dual_scan_i), .ovl1_en_i(ovl1_en_i),
    .ovl2_en_i(ovl2_en_i), .cursor_en_i(cursor_en_i),
    .wr_en_i(wr_en_i), .wr_branch_i(wr_branch_i), .wr_ch_i(wr_ch_i),
    .wr_data_i(wr_data_i), .rd_ch_i(rd_ch_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
    .bs_evt_o(bs_evt_o), .ber_evt_o(ber_evt_o), .done_o(done_o));

  int n_chk = 0, n_fail = 0, done_cnt = 0;
  int lat_cnt = 0, lat_target = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] m_next [NCH], m_src [NCH], m_id [NCH], m_cmd [NCH], m_br [NCH];
  logic [31:0] exp_addr [$];
  int exp_ev [$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mem(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic bit ch_on(int ch);
    case (ch)
      0: return lcd_en_i;
      1: return ovl1_en_i | dual_scan_i;
      2, 3, 4: return ovl2_en_i;
      5: return cursor_en_i;
      default: return 1'b0;
    endcase
  endfunction

  task automatic put_desc(logic [31:0] a, logic [31:0] nx, logic [31:0] s,
                          logic [31:0] id, logic [31:0] cmd);
    mem[a] = nx; mem[a+4] = s; mem[a+8] = id; mem[a+12] = cmd;
  endtask

  task automatic sw_wr(bit br, int ch, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_branch_i = br; wr_ch_i = 3'(ch); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
    if (br) m_br[ch] = d & 32'hFFFF_FFF3;
    else m_next[ch] = d & 32'hFFFF_FFF0;
  endtask

  task automatic rd_reg(int ch, int sel, output logic [31:0] v);
    rd_ch_i = 3'(ch); rd_sel_i = 3'(sel);
    #1 v = rd_data_o;
  endtask

  task automatic check_regs(string tag);
    logic [31:0] v;
    for (int ch = 0; ch < NCH; ch++) begin
      rd_reg(ch, 0, v); check({tag, " R2 next"}, v, m_next[ch]);
      rd_reg(ch, 1, v); check({tag, " R7 R8 source"}, v, m_src[ch]);
      rd_reg(ch, 2, v); check({tag, " R2 id"}, v, m_id[ch]);
      rd_reg(ch, 3, v); check({tag, " R2 cmd"}, v, m_cmd[ch]);
      rd_reg(ch, 4, v); check({tag, " R4 branch"}, v, m_br[ch]);
      rd_reg(ch, 5, v); check({tag, " R12 length"}, v, m_cmd[ch] & 32'h001F_FFFC);
      rd_reg(ch, 6, v); check({tag, " R12 palette"}, v, {31'd0, m_cmd[ch][26]});
    end
  endtask

  task automatic model_pass();
    logic [31:0] ptr;
    longint unsigned p, s;
    for (int ch = 0; ch < NCH; ch++) m_src[ch] = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (!ch_on(ch)) continue;
      if (m_br[ch][0]) begin
        ptr = m_br[ch] & 32'hFFFF_FFF0;
        if (m_br[ch][1]) exp_ev.push_back(ch * 2);
        m_br[ch][0] = 1'b0;
      end else ptr = m_next[ch];
      p = longint'(ptr);
      if (p >= longint'(BASE) && p + 16 <= longint'(BASE) + longint'(SIZE)) begin
        for (int w = 0; w < 4; w++) exp_addr.push_back(ptr + 32'(4 * w));
        m_next[ch] = rd_mem(ptr);
        m_src[ch] = rd_mem(ptr + 4);
        m_id[ch] = rd_mem(ptr + 8);
        m_cmd[ch] = rd_mem(ptr + 12);
      end
      s = longint'(m_src[ch]);
      if (s == 0 || s < longint'(BASE) || s > longint'(BASE) + longint'(SIZE))
        exp_ev.push_back(ch * 2 + 1);
    end
  endtask

  task automatic run_frame(string tag, bit extra_start);
    int d0, t;
    model_pass();
    d0 = done_cnt;
    @(negedge clk); frame_start_i = 1;
    @(negedge clk); frame_start_i = 0;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      frame_start_i = 1;
      @(negedge clk); frame_start_i = 0;
    end
    t = 0;
    while (done_cnt == d0 && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    check({tag, " R11 one done per pass"}, 32'(done_cnt - d0), 32'd1);
    check({tag, " R2 R10 reads left"}, 32'(exp_addr.size()), 32'd0);
    check({tag, " R5 R8 events left"}, 32'(exp_ev.size()), 32'd0);
    exp_addr.delete(); exp_ev.delete();
    check_regs(tag);
  endtask

  // memory responder and per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni) begin
      if (mem_req_o) begin
        if (lat_cnt >= lat_target) begin
          mem_valid_i = 1; mem_rdata_i = rd_mem(mem_addr_o);
        end else begin
          mem_valid_i = 0; lat_cnt++;
        end
      end else mem_valid_i = 0;
      if (mem_req_o && mem_valid_i) begin
        if (exp_addr.size() == 0) check("R9 R10 unexpected read", mem_addr_o, 32'hDEAD_BEEF);
        else check("R2 R10 read address", mem_addr_o, exp_addr.pop_front());
        lat_cnt = 0; lat_target = (lat_target + 1) % 3;
      end
      for (int ch = 0; ch < NCH; ch++) begin
        if (bs_evt_o[ch]) begin
          if (exp_ev.size() == 0) check("R5 unexpected branch event", 32'(ch), 32'hFF);
          else check("R5 branch event", 32'(ch * 2), 32'(exp_ev.pop_front()));
        end
        if (ber_evt_o[ch]) begin
          if (exp_ev.size() == 0) check("R8 unexpected bus error", 32'(ch), 32'hFF);
          else check("R8 bus error event", 32'(ch * 2 + 1), 32'(exp_ev.pop_front()));
        end
      end
      if (done_o) done_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int ch = 0; ch < NCH; ch++) begin
      m_next[ch] = 0; m_src[ch] = 0; m_id[ch] = 0; m_cmd[ch] = 0; m_br[ch] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 request at reset", {31'd0, mem_req_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk);
    check("R1 done after reset", {31'd0, done_o}, 32'd0);
    check_regs("R1 reset");

    // R3 write masks
    sw_wr(0, 0, 32'hFFFF_FFFF); rd_reg(0, 0, v); check("R3 next mask", v, 32'hFFFF_FFF0);
    sw_wr(1, 0, 32'hFFFF_FFFF); rd_reg(0, 4, v); check("R3 branch mask", v, 32'hFFFF_FFF3);
    sw_wr(1, 0, 32'h0);
    sw_wr(0, 0, 32'h0000_1100);

    put_desc(32'h1100, 32'h1200, 32'h1800, 32'hA5, 32'h0400_0104);
    put_desc(32'h1200, 32'h1100, 32'h1900, 32'h5A, 32'h0000_0FFF);
    put_desc(32'h1300, 32'h1200, 32'h1A00, 32'h77, 32'h0020_0040);
    lcd_en_i = 1;
    run_frame("R2 chain a", 0);
    run_frame("R2 chain b", 0);
    run_frame("R2 chain c", 0);

    // R4 R5 branch variants
    sw_wr(1, 0, 32'h0000_1303); run_frame("R4 R5 branch with irq", 0);
    run_frame("R4 chain after branch", 0);
    sw_wr(1, 0, 32'h0000_1302); run_frame("R5 irq bit without pending", 0);
    sw_wr(1, 0, 32'h0000_1301); run_frame("R4 R5 pending without irq", 0);

    // R6 R8 window edges
    put_desc(32'h1FF0, 32'h2000, 32'h2000, 32'h1, 32'h0);
    sw_wr(0, 0, 32'h0000_1FF0); run_frame("R6 R8 top-fit desc, top source", 0);
    run_frame("R6 desc at window top", 0);
    sw_wr(0, 0, 32'h0000_0FF0); run_frame("R6 desc below base", 0);
    put_desc(32'h1400, 32'h1400, 32'h0, 32'h2, 32'h0);
    sw_wr(0, 0, 32'h0000_1400); run_frame("R8 zero source", 0);
    put_desc(32'h1500, 32'h1500, 32'h2004, 32'h3, 32'h0);
    sw_wr(0, 0, 32'h0000_1500); run_frame("R8 source above window", 0);
    put_desc(32'h1510, 32'h1510, 32'h0FFC, 32'h4, 32'h0);
    sw_wr(0, 0, 32'h0000_1510); run_frame("R8 source below base", 0);

    // R7 R9 enable mapping
    for (int ch = 0; ch < NCH; ch++) begin
      put_desc(32'h1600 + 32'(ch * 32), 32'h1600 + 32'(ch * 32),
               32'h1700 + 32'(ch * 16), 32'h10 + 32'(ch), 32'(ch) << 24);
      sw_wr(0, ch, 32'h1600 + 32'(ch * 32));
    end
    sw_wr(1, 3, 32'h0000_1603 + 32'(3 * 32) - 32'h3);
    sw_wr(1, 3, 32'h0000_1663);
    lcd_en_i = 0; ovl2_en_i = 1;
    run_frame("R7 R9 overlay2 only", 0);
    ovl2_en_i = 0; dual_scan_i = 1;
    run_frame("R7 R9 dual scan only", 0);
    dual_scan_i = 0; lcd_en_i = 1; ovl1_en_i = 1; ovl2_en_i = 1; cursor_en_i = 1;
    run_frame("R9 R10 R11 all on, restart ignored", 1);
    lcd_en_i = 0; ovl2_en_i = 0; cursor_en_i = 0;
    run_frame("R7 R9 overlay1 only", 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule